// File: doc/BRIEF.md
# DMA Bridge Interrupt Status Controller

This block collects event pulses from a DMA bridge and turns them into three interrupt request lines and a 2-bit code that names the most urgent line. The bridge serves two audio channels, each with a receive and a transmit lane, one USB requester and one display requester. Each interrupting event has an enable bit and a sticky flag. Software writes the enable word directly. It clears flags by writing 0 to them, and bits written as 1 are left untouched.

The events come in three groups. The first is a USB address error. The second is end of transfer, with five sources: the four audio lanes and USB. The third is the half-way point of each audio lane. The block finds the half-way point itself. A load pulse arms a per-lane byte counter with the programmed length. Each beat pulse adds a fixed number of bytes, and the event fires once, on the first beat that brings the count to half the length. The display requester has an input for its completion pulse, but that input never raises anything.

All outputs are registered. Flags, enables, lines and code all change on the same clock edge as the event or write that causes them.

Top module: `dmab_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all flags, all enables, the three lines and the code are 0.
- R2: `usb_addr_err` with enable bit 0 set raises flag bit 0 and `irq_addr_err` at the next clock edge.
- R3: End-of-transfer events set flag bits 1 to 5. Bits 1 to 4 are `aud_done` lanes 0 to 3 (lane = 2*channel + direction, receive = 0). Bit 5 is `usb_done`. Each bit is set only when its own enable is set, and `irq_all_end` goes high.
- R4: `aud_load[k]` arms lane k with target `aud_len >> 1` and count 0. Each `aud_beat[k]` adds BEAT_BYTES. On the first beat where the count is at least the target, flag bit 6+k is set if its enable is 1, and `irq_half_end` goes high.
- R5: The half-way event fires at most once per load. Further beats do nothing until the next load. A load in the same cycle as a beat discards that beat.
- R6: An event that arrives while its enable is 0 leaves its flag at 0, and setting the enable later does not set the flag.
- R7: Flags are sticky. A cycle with `sw_clr_we` high clears each flag whose `sw_clr_wdata` bit is 0 and keeps each flag whose bit is 1.
- R8: If an enabled event and a clear of the same flag happen in the same cycle, the flag stays 1.
- R9: Each line is the OR of its group's flags ANDed with their enables. Clearing an enable drops that flag's contribution to the line but keeps the flag.
- R10: `irq_code` is 1 when `irq_addr_err` is high. Otherwise it is 2 when `irq_all_end` is high, otherwise 3 when `irq_half_end` is high, otherwise 0.
- R11: `disp_done` changes no flag, line or code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_en_we | input | 1 | Write strobe for the enable word |
| sw_en_wdata | input | 10 | New enable word |
| sw_clr_we | input | 1 | Write strobe for flag clearing |
| sw_clr_wdata | input | 10 | 0 bits clear flags, 1 bits keep them |
| usb_addr_err | input | 1 | USB address error pulse |
| usb_done | input | 1 | USB transfer complete pulse |
| aud_done | input | 4 | Audio lane transfer complete pulses |
| aud_load | input | 4 | Audio lane length load pulses |
| aud_len | input | 12 | Programmed byte length, shared by the load pulses |
| aud_beat | input | 4 | Audio lane beat pulses, BEAT_BYTES each |
| disp_done | input | 1 | Display requester completion, no effect |
| flags_o | output | 10 | Sticky flags |
| enables_o | output | 10 | Enable word |
| irq_addr_err | output | 1 | Address error line |
| irq_all_end | output | 1 | End-of-transfer line |
| irq_half_end | output | 1 | Half-way line |
| irq_code | output | 2 | Code of the highest-priority active line |

## Verification
The directed patterns are chosen to separate similar faults:
- Events with enables off versus on show whether the enable gates the flag setting or only the line.
- Partial clears with mixed write bits show whether a write bit of 1 keeps a flag or clears it.
- An event and a clear in the same cycle shows which one wins.
- Half-way runs with an even length, a length of 1, extra beats after firing, and a load that coincides with a beat separate a `>=` compare from `==`, and single firing from repeated firing.
- A random phase mixes all inputs against the reference model, to exercise the priority code across combinations of active lines.

// File: rtl/dmab_irq_pkg.sv
package dmab_irq_pkg;

  typedef enum logic [1:0] {
    CODE_NONE = 2'd0,
    CODE_ADDR = 2'd1,
    CODE_ALL  = 2'd2,
    CODE_HALF = 2'd3
  } irq_code_e;

  typedef struct packed {
    logic addr;
    logic all_end;
    logic half_end;
  } irq_lines_t;

endpackage

// File: rtl/dmab_half_det.sv
module dmab_half_det #(
  parameter int CNT_W      = 12,
  parameter int BEAT_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             beat,
  output logic             fire
);

  localparam logic [CNT_W:0] STEP = (CNT_W+1)'(BEAT_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt_q;
  logic             armed_q;
  logic [CNT_W:0]   sum;

  assign sum  = {1'b0, cnt_q} + STEP;
  assign fire = armed_q & beat & ~load & (sum >= {1'b0, tgt_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      tgt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= '0;
      tgt_q   <= len >> 1;
      armed_q <= 1'b1;
    end else if (beat && armed_q) begin
      cnt_q <= sum[CNT_W-1:0];
      if (fire) armed_q <= 1'b0;
    end
  end

  // R5
  half_once_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

  // R5
  rearm_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> armed_q);

endmodule

// File: rtl/dmab_flag_bank.sv
module dmab_flag_bank #(
  parameter int NEV = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] evt,
  input  logic           en_we,
  input  logic [NEV-1:0] en_wdata,
  input  logic           clr_we,
  input  logic [NEV-1:0] clr_wdata,
  output logic [NEV-1:0] flag_q,
  output logic [NEV-1:0] en_q,
  output logic [NEV-1:0] flag_nx,
  output logic [NEV-1:0] en_nx
);

  for (genvar i = 0; i < NEV; i++) begin : g_bit
    logic keep;
    assign keep       = flag_q[i] & ~(clr_we & ~clr_wdata[i]);
    assign flag_nx[i] = keep | (evt[i] & en_q[i]);

    // R6
    no_set_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      (!flag_q[i] && !en_q[i]) |=> !flag_q[i]);

    // R8
    evt_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (evt[i] && en_q[i]) |=> flag_q[i]);

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !clr_we) |=> flag_q[i]);
  end

  assign en_nx = en_we ? en_wdata : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_nx;
      en_q   <= en_nx;
    end
  end

endmodule

// File: rtl/dmab_irq_prio.sv
module dmab_irq_prio
  import dmab_irq_pkg::*;
#(
  parameter int NAUD = 4,
  parameter int NEV  = 2 * NAUD + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] flag_nx,
  input  logic [NEV-1:0] en_nx,
  output irq_lines_t     lines_q,
  output irq_code_e      code_q
);

  localparam int DONE_LO = 1;
  localparam int DONE_HI = NAUD + 1;
  localparam int HALF_LO = NAUD + 2;

  logic [NEV-1:0] act;
  irq_lines_t     lines_d;
  irq_code_e      code_d;

  assign act = flag_nx & en_nx;

  always_comb begin
    lines_d.addr     = act[0];
    lines_d.all_end  = |act[DONE_HI:DONE_LO];
    lines_d.half_end = |act[NEV-1:HALF_LO];
    if (lines_d.addr)          code_d = CODE_ADDR;
    else if (lines_d.all_end)  code_d = CODE_ALL;
    else if (lines_d.half_end) code_d = CODE_HALF;
    else                       code_d = CODE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q <= '0;
      code_q  <= CODE_NONE;
    end else begin
      lines_q <= lines_d;
      code_q  <= code_d;
    end
  end

  // R10
  code_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (code_q == CODE_NONE) |-> (lines_q == '0));

  // R10
  addr_first_chk: assert property (@(posedge clk) disable iff (rst)
    lines_q.addr |-> (code_q == CODE_ADDR));

  // R10
  all_before_half_chk: assert property (@(posedge clk) disable iff (rst)
    (!lines_q.addr && lines_q.all_end) |-> (code_q == CODE_ALL));

endmodule

// File: rtl/dmab_irq_ctrl.sv
module dmab_irq_ctrl
  import dmab_irq_pkg::*;
#(
  parameter int  NCH        = 2,
  parameter int  CNT_W      = 12,
  parameter int  BEAT_BYTES = 4,
  localparam int NAUD       = 2 * NCH,
  localparam int NEV        = 2 * NAUD + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_en_we,
  input  logic [NEV-1:0]   sw_en_wdata,
  input  logic             sw_clr_we,
  input  logic [NEV-1:0]   sw_clr_wdata,
  input  logic             usb_addr_err,
  input  logic             usb_done,
  input  logic [NAUD-1:0]  aud_done,
  input  logic [NAUD-1:0]  aud_load,
  input  logic [CNT_W-1:0] aud_len,
  input  logic [NAUD-1:0]  aud_beat,
  input  logic             disp_done,
  output logic [NEV-1:0]   flags_o,
  output logic [NEV-1:0]   enables_o,
  output logic             irq_addr_err,
  output logic             irq_all_end,
  output logic             irq_half_end,
  output logic [1:0]       irq_code
);

  localparam int IDX_ADDR = 0;
  localparam int IDX_DONE = 1;
  localparam int IDX_USB  = NAUD + 1;
  localparam int IDX_HALF = NAUD + 2;

  logic [NAUD-1:0] half_fire;
  logic [NEV-1:0]  evt;
  logic [NEV-1:0]  flag_nx;
  logic [NEV-1:0]  en_nx;
  irq_lines_t      lines_q;
  irq_code_e       code_q;

  for (genvar k = 0; k < NAUD; k++) begin : g_lane
    dmab_half_det #(
      .CNT_W      (CNT_W),
      .BEAT_BYTES (BEAT_BYTES)
    ) u_half (
      .clk  (clk),
      .rst  (rst),
      .load (aud_load[k]),
      .len  (aud_len),
      .beat (aud_beat[k]),
      .fire (half_fire[k])
    );
  end

  always_comb begin
    evt                           = '0;
    evt[IDX_ADDR]                 = usb_addr_err;
    evt[IDX_DONE +: NAUD]         = aud_done;
    evt[IDX_USB]                  = usb_done;
    evt[IDX_HALF +: NAUD]         = half_fire;
  end

  dmab_flag_bank #(
    .NEV (NEV)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .en_we     (sw_en_we),
    .en_wdata  (sw_en_wdata),
    .clr_we    (sw_clr_we),
    .clr_wdata (sw_clr_wdata),
    .flag_q    (flags_o),
    .en_q      (enables_o),
    .flag_nx   (flag_nx),
    .en_nx     (en_nx)
  );

  dmab_irq_prio #(
    .NAUD (NAUD),
    .NEV  (NEV)
  ) u_prio (
    .clk     (clk),
    .rst     (rst),
    .flag_nx (flag_nx),
    .en_nx   (en_nx),
    .lines_q (lines_q),
    .code_q  (code_q)
  );

  assign irq_addr_err = lines_q.addr;
  assign irq_all_end  = lines_q.all_end;
  assign irq_half_end = lines_q.half_end;
  assign irq_code     = code_q;

  // R11
  disp_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_done && !usb_addr_err && !usb_done && (aud_done == '0) &&
     (aud_beat == '0) && !sw_clr_we) |=> $stable(flags_o));

  // R2
  addr_err_line_chk: assert property (@(posedge clk) disable iff (rst)
    (usb_addr_err && enables_o[IDX_ADDR] && !sw_en_we) |=> irq_addr_err);

endmodule

// File: tb/tb_dmab_irq_ctrl.sv
module tb_dmab_irq_ctrl;
  localparam int CW = 12;
  localparam int BB = 4;
  localparam int NA = 4;
  localparam int NE = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sw_en_we = 1'b0;
  logic [NE-1:0] sw_en_wdata = '0;
  logic          sw_clr_we = 1'b0;
  logic [NE-1:0] sw_clr_wdata = '0;
  logic          usb_addr_err = 1'b0;
  logic          usb_done = 1'b0;
  logic [NA-1:0] aud_done = '0;
  logic [NA-1:0] aud_load = '0;
  logic [CW-1:0] aud_len = '0;
  logic [NA-1:0] aud_beat = '0;
  logic          disp_done = 1'b0;
  logic [NE-1:0] flags_o;
  logic [NE-1:0] enables_o;
  logic          irq_addr_err;
  logic          irq_all_end;
  logic          irq_half_end;
  logic [1:0]    irq_code;

  dmab_irq_ctrl dut (
    .clk(clk), .rst(rst),
    .sw_en_we(sw_en_we), .sw_en_wdata(sw_en_wdata),
    .sw_clr_we(sw_clr_we), .sw_clr_wdata(sw_clr_wdata),
    .usb_addr_err(usb_addr_err), .usb_done(usb_done),
    .aud_done(aud_done), .aud_load(aud_load), .aud_len(aud_len),
    .aud_beat(aud_beat), .disp_done(disp_done),
    .flags_o(flags_o), .enables_o(enables_o),
    .irq_addr_err(irq_addr_err), .irq_all_end(irq_all_end),
    .irq_half_end(irq_half_end), .irq_code(irq_code)
  );

  always #5 clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  string phase = "R1";
  bit    started = 1'b0;
  bit    finished = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit [NE-1:0] m_flag, m_en, m_ev, m_act;
  int          m_cnt[NA];
  int          m_tgt[NA];
  bit          m_arm[NA];
  bit          m_addr, m_all, m_half;
  int          m_code;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_flag = '0; m_en = '0; m_addr = 0; m_all = 0; m_half = 0; m_code = 0;
      for (int a = 0; a < NA; a++) begin m_cnt[a] = 0; m_tgt[a] = 0; m_arm[a] = 0; end
    end else begin
      m_ev = '0;
      m_ev[0] = usb_addr_err;
      for (int a = 0; a < NA; a++) m_ev[1+a] = aud_done[a];
      m_ev[5] = usb_done;
      for (int a = 0; a < NA; a++) begin
        if (aud_load[a]) begin
          m_cnt[a] = 0; m_tgt[a] = int'(aud_len) / 2; m_arm[a] = 1;
        end else if (aud_beat[a] && m_arm[a]) begin
          m_cnt[a] += BB;
          if (m_cnt[a] >= m_tgt[a]) begin m_ev[6+a] = 1; m_arm[a] = 0; end
        end
      end
      for (int i = 0; i < NE; i++)
        m_flag[i] = (m_flag[i] && !(sw_clr_we && !sw_clr_wdata[i])) || (m_ev[i] && m_en[i]);
      if (sw_en_we) m_en = sw_en_wdata;
      m_act  = m_flag & m_en;
      m_addr = m_act[0];
      m_all  = |m_act[5:1];
      m_half = |m_act[9:6];
      m_code = m_addr ? 1 : m_all ? 2 : m_half ? 3 : 0;
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      check({phase, " model flags"}, int'(flags_o), int'(m_flag));
      check({phase, " model enables"}, int'(enables_o), int'(m_en));
      check({phase, " model lines"}, int'({irq_addr_err, irq_all_end, irq_half_end}),
            int'({m_addr, m_all, m_half}));
      check({phase, " model code"}, int'(irq_code), m_code);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R1 flags", int'(flags_o), 0);
    check("R1 enables", int'(enables_o), 0);
    check("R1 lines", int'({irq_addr_err, irq_all_end, irq_half_end}), 0);
    check("R1 code", int'(irq_code), 0);
    rst = 1'b0;
    tick();

    phase = "R6";
    usb_addr_err = 1; aud_done = 4'hF; usb_done = 1;
    tick();
    usb_addr_err = 0; aud_done = 0; usb_done = 0;
    check("R6 flags stay 0", int'(flags_o), 0);
    sw_en_we = 1; sw_en_wdata = 10'h3FF;
    tick();
    sw_en_we = 0;
    check("R6 enables", int'(enables_o), 10'h3FF);
    check("R6 no late set", int'(flags_o), 0);
    check("R6 line low", int'(irq_all_end), 0);

    phase = "R2";
    usb_addr_err = 1;
    tick();
    usb_addr_err = 0;
    check("R2 flag", int'(flags_o[0]), 1);
    check("R2 line", int'(irq_addr_err), 1);
    check("R10 code addr", int'(irq_code), 1);

    phase = "R3";
    aud_done = 4'b0101; usb_done = 1;
    tick();
    aud_done = 0; usb_done = 0;
    check("R3 done flags", int'(flags_o[5:1]), 5'b10101);
    check("R3 line", int'(irq_all_end), 1);
    check("R10 addr over all", int'(irq_code), 1);

    phase = "R7";
    sw_clr_we = 1; sw_clr_wdata = 10'h3FE;
    tick();
    sw_clr_we = 0;
    check("R7 partial clear", int'(flags_o), 10'h02A);
    check("R7 addr line low", int'(irq_addr_err), 0);
    check("R10 code all", int'(irq_code), 2);

    phase = "R9";
    sw_en_we = 1; sw_en_wdata = 10'h3C1;
    tick();
    sw_en_we = 0;
    check("R9 line follows enable", int'(irq_all_end), 0);
    check("R9 flags kept", int'(flags_o), 10'h02A);
    check("R10 code none", int'(irq_code), 0);

    phase = "R4";
    aud_len = 12'd16; aud_load[2] = 1;
    tick();
    aud_load = 0; aud_beat[2] = 1;
    tick();
    aud_beat = 0;
    check("R4 below half", int'(flags_o[8]), 0);
    aud_beat[2] = 1;
    tick();
    aud_beat = 0;
    check("R4 at half", int'(flags_o[8]), 1);
    check("R4 line", int'(irq_half_end), 1);
    check("R10 code half", int'(irq_code), 3);

    phase = "R5";
    sw_clr_we = 1; sw_clr_wdata = ~(10'h1 << 8);
    tick();
    sw_clr_we = 0;
    aud_beat[2] = 1;
    repeat (3) tick();
    aud_beat = 0;
    check("R5 fires once", int'(flags_o[8]), 0);
    aud_len = 12'd6; aud_load[2] = 1; aud_beat[2] = 1;
    tick();
    aud_load = 0;
    check("R5 load drops beat", int'(flags_o[8]), 0);
    tick();
    aud_beat = 0;
    check("R5 rearmed", int'(flags_o[8]), 1);

    phase = "R8";
    usb_addr_err = 1; sw_clr_we = 1; sw_clr_wdata = ~10'h1;
    tick();
    usb_addr_err = 0; sw_clr_we = 0;
    check("R8 event wins", int'(flags_o[0]), 1);
    check("R8 line", int'(irq_addr_err), 1);

    phase = "R11";
    sw_clr_we = 1; sw_clr_wdata = '0;
    tick();
    sw_clr_we = 0; disp_done = 1;
    repeat (3) tick();
    disp_done = 0;
    check("R11 flags", int'(flags_o), 0);
    check("R11 code", int'(irq_code), 0);

    phase = "R4";
    aud_len = 12'd1; aud_load[0] = 1;
    tick();
    aud_load = 0; aud_beat[0] = 1;
    tick();
    aud_beat = 0;
    check("R4 tiny length", int'(flags_o[6]), 1);

    phase = "R9";
    for (int c = 0; c < 600; c++) begin
      usb_addr_err = ($urandom % 16) == 0;
      usb_done     = ($urandom % 16) == 0;
      aud_done     = 4'(($urandom % 8) == 0 ? $urandom : 0);
      aud_load     = 4'(($urandom % 10) == 0 ? $urandom : 0);
      aud_len      = 12'($urandom % 64);
      aud_beat     = 4'($urandom);
      disp_done    = 1'($urandom);
      sw_en_we     = ($urandom % 12) == 0;
      sw_en_wdata  = 10'($urandom);
      sw_clr_we    = ($urandom % 4) == 0;
      sw_clr_wdata = 10'($urandom);
      tick();
    end
    usb_addr_err = 0; usb_done = 0; aud_done = 0; aud_load = 0;
    aud_beat = 0; disp_done = 0; sw_en_we = 0; sw_clr_we = 0;
    tick();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule